// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register File

This block holds the register state and control for one digitally controlled potentiometer with a 7-bit wiper. A serial front end decodes the bus frames and hands the block single read and write requests: a two-bit address, a data byte and a direction. The block returns the read byte one cycle later. It drives the live wiper code toward the resistor array and an effective shutdown flag.

Two storage locations share address 00. The live wiper register is volatile. The startup register is non-volatile, and a control bit chooses which of the two the address reaches. A write to the startup register also moves the live wiper at once. The front end pulses `frame_done` when chip select rises, and that pulse starts a timed store to the non-volatile copy. The store lasts `STORE_CYCLES` clocks, and a busy flag is visible during it.

While `supply_good` is low the wiper sits at midscale. On the first cycle with a good supply, the stored startup code is copied into the wiper. Shutdown is the OR of a pin request and a control bit, and it never alters the wiper code.

Top module: `potwiper_regfile`

## Requirements
- R1: While `supply_good` is low, `wiper_code` is midscale (40h) one edge later. After `rst_n`, the control register reads C=0 (bit 7), E=1 (bit 6).
- R2: On the first edge with `supply_good` high after it was low, `wiper_code` loads the stored startup code. Reset sets that code to `IVR_INIT`.
- R3: Address 00 reads or writes the live wiper when C=1 and the startup register when C=0. Address 10 is the control register. Addresses 01 and 11 read 00h and ignore writes. `rd_data` updates one edge after a read request.
- R4: The control byte is {C, E, busy, 5'b0}. A write sets only C from bit 7 and E from bit 6. The busy bit and bits 4:0 ignore writes.
- R5: An accepted write to address 00 keeps data bits 6:0 and sets `wiper_code` one edge later, whatever C is. Reading the startup register leaves `wiper_code` unchanged.
- R6: A `frame_done` pulse after an accepted startup-register write raises `busy` on the next edge. `busy` stays high for exactly `STORE_CYCLES` cycles. After that, reads of the startup register return the new code. A `frame_done` pulse with no pending write does not raise `busy`.
- R7: While `busy` is high, every write is ignored, and reads are still served.
- R8: `shutdown` is high when `run_pin` is low or E is 0, and low only when both are high.
- R9: Entering and leaving shutdown leaves `wiper_code` unchanged. All registers stay readable and writable in shutdown.
- R10: Requests are ignored while `supply_good` is low and on the recall edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | High once the supply is reliable |
| run_pin | input | 1 | Low requests shutdown |
| req_valid | input | 1 | Request strobe from the serial front end |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data byte |
| frame_done | input | 1 | One-cycle pulse at the end of a frame |
| rd_data | output | 8 | Read data, valid one edge after the request |
| wiper_code | output | 7 | Live wiper code, 00h nearest the low terminal |
| busy | output | 1 | Non-volatile store in progress |
| shutdown | output | 1 | Effective shutdown |

## Verification
The stimulus covers several patterns:
- A power-up with a startup code that differs from midscale, which shows the forced midscale apart from the recall.
- Writes through address 00 with C at both values, which show which storage the shared address reached.
- Writes and frame ends issued in the middle of a store, which show lockout against normal acceptance.
- Shutdown driven from the pin, from the control bit and from both.
- A supply drop with requests held active, which shows the power-down and recall windows.

A behavioural model in the bench predicts every output on each clock.

// File: rtl/potwiper_pkg.sv
package potwiper_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_POS  = 2'b00,
    ADDR_RSV0 = 2'b01,
    ADDR_CTL  = 2'b10,
    ADDR_RSV1 = 2'b11
  } reg_addr_e;

  // control byte bit positions
  localparam int CTL_SEL_BIT  = 7;
  localparam int CTL_RUN_BIT  = 6;
  localparam int CTL_BUSY_BIT = 5;
endpackage

// File: rtl/potwiper_nvstore.sv
module potwiper_nvstore #(
  parameter int W = 7,
  parameter int STORE_CYCLES = 2000000,
  parameter logic [W-1:0] INIT_CODE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         frame_end,
  output logic         busy,
  output logic [W-1:0] stored
);
  localparam int CW = $clog2(STORE_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic [W-1:0]  pval_q, pval_d;
  logic [W-1:0]  nv_q, nv_d;
  logic          start;

  assign busy   = (cnt_q != '0);
  assign stored = nv_q;
  assign start  = frame_end && !busy && (pend_q || load_en);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    pval_d = pval_q;
    nv_d   = nv_q;
    if (load_en) begin
      pval_d = load_val;
      pend_d = 1'b1;
    end
    if (busy) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) nv_d = pval_q;
    end else if (start) begin
      cnt_d  = CW'(STORE_CYCLES);
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      pval_q <= '0;
      nv_q   <= INIT_CODE;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      pval_q <= pval_d;
      nv_q   <= nv_d;
    end
  end
endmodule

// File: rtl/potwiper_regs.sv
module potwiper_regs
  import potwiper_pkg::*;
#(
  parameter int W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_good,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              busy,
  input  logic [W-1:0]      stored,
  output logic [W-1:0]      wiper,
  output logic              ctl_sel,
  output logic              ctl_run,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ivr_load,
  output logic              req_ok
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  localparam int PAD = BYTE_W - W;

  logic              sg_q;
  logic [W-1:0]      wr_q, wr_d;
  logic              sel_q, sel_d, run_q, run_d;
  logic [BYTE_W-1:0] rd_q, rd_d;
  logic              wr_acc, rd_acc;
  reg_addr_e         addr;

  assign addr     = reg_addr_e'(req_addr);
  assign req_ok   = supply_good && sg_q;
  assign wr_acc   = req_ok && req_valid && req_write && !busy;
  assign rd_acc   = req_ok && req_valid && !req_write;
  assign ivr_load = wr_acc && (addr == ADDR_POS) && !sel_q;

  always_comb begin
    wr_d  = wr_q;
    sel_d = sel_q;
    run_d = run_q;
    rd_d  = rd_q;
    if (!supply_good)                       wr_d = MID;
    else if (!sg_q)                         wr_d = stored;
    else if (wr_acc && addr == ADDR_POS)    wr_d = req_wdata[W-1:0];
    if (wr_acc && addr == ADDR_CTL) begin
      sel_d = req_wdata[CTL_SEL_BIT];
      run_d = req_wdata[CTL_RUN_BIT];
    end
    if (rd_acc) begin
      rd_d = '0;
      unique case (addr)
        ADDR_POS: rd_d = {{PAD{1'b0}}, (sel_q ? wr_q : stored)};
        ADDR_CTL: begin
          rd_d[CTL_SEL_BIT]  = sel_q;
          rd_d[CTL_RUN_BIT]  = run_q;
          rd_d[CTL_BUSY_BIT] = busy;
        end
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_q  <= 1'b0;
      wr_q  <= MID;
      sel_q <= 1'b0;
      run_q <= 1'b1;
      rd_q  <= '0;
    end else begin
      sg_q  <= supply_good;
      wr_q  <= wr_d;
      sel_q <= sel_d;
      run_q <= run_d;
      rd_q  <= rd_d;
    end
  end

  assign wiper   = wr_q;
  assign ctl_sel = sel_q;
  assign ctl_run = run_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/potwiper_regfile.sv
module potwiper_regfile #(
  parameter int W = 7,
  parameter int STORE_CYCLES = 2000000,
  parameter logic [W-1:0] IVR_INIT = 7'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_good,
  input  logic         run_pin,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [1:0]   req_addr,
  input  logic [7:0]   req_wdata,
  input  logic         frame_done,
  output logic [7:0]   rd_data,
  output logic [W-1:0] wiper_code,
  output logic         busy,
  output logic         shutdown
);
  logic [W-1:0] nv_val;
  logic         ivr_load;
  logic         ctl_sel;
  logic         ctl_run;
  logic         req_ok;

  potwiper_nvstore #(
    .W(W), .STORE_CYCLES(STORE_CYCLES), .INIT_CODE(IVR_INIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .load_en(ivr_load),
    .load_val(req_wdata[W-1:0]), .frame_end(frame_done),
    .busy(busy), .stored(nv_val)
  );

  potwiper_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .stored(nv_val),
    .wiper(wiper_code), .ctl_sel(ctl_sel), .ctl_run(ctl_run),
    .rd_data(rd_data), .ivr_load(ivr_load), .req_ok(req_ok)
  );

  assign shutdown = !run_pin || !ctl_run;
endmodule

// File: rtl/potwiper_chk.sv
module potwiper_chk #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         supply_good,
  input logic         run_pin,
  input logic         req_valid,
  input logic         req_write,
  input logic [1:0]   req_addr,
  input logic         frame_done,
  input logic [7:0]   rd_data,
  input logic [W-1:0] wiper_code,
  input logic         busy,
  input logic         shutdown,
  input logic [W-1:0] stored,
  input logic         req_ok
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  // R1
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> wiper_code == MID);

  // R2
  recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_good) |=> wiper_code == $past(stored));

  // R4
  ctl_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok && req_valid && !req_write && req_addr == 2'b10
    |=> rd_data[4:0] == 5'd0 && rd_data[5] == $past(busy));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_done));

  // R7
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_ok && req_valid && req_write |=> $stable(wiper_code));

  // R8
  pin_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_pin |-> shutdown);

  // R10
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ok |=> $stable(rd_data));
endmodule

bind potwiper_regfile potwiper_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .run_pin(run_pin),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .frame_done(frame_done), .rd_data(rd_data), .wiper_code(wiper_code),
  .busy(busy), .shutdown(shutdown), .stored(nv_val), .req_ok(req_ok)
);

// File: tb/potwiper_regfile_test.sv
`timescale 1ns/1ps
module potwiper_regfile_test;
  localparam int N = 40;
  localparam logic [6:0] INIT = 7'h15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0, run_pin = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, frame_done = 1'b0;
  logic [1:0] req_addr = 2'b00;
  logic [7:0] req_wdata = 8'h00;
  logic [7:0] rd_data;
  logic [6:0] wiper_code;
  logic busy, shutdown;

  int checks = 0, failures = 0, cycles = 0, busy_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  potwiper_regfile #(.W(7), .STORE_CYCLES(N), .IVR_INIT(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .run_pin(run_pin),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .frame_done(frame_done), .rd_data(rd_data),
    .wiper_code(wiper_code), .busy(busy), .shutdown(shutdown)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_wr, m_vol, m_shdn, m_nv, m_pend, m_pf, m_cnt, m_rd, m_sgq;
  always @(posedge clk) begin
    int ok, b, wacc, ld, nwr, nvol, nshdn, nnv, npend, npf, ncnt, nrd;
    if (!rst_n) begin
      m_wr = 64; m_vol = 0; m_shdn = 1; m_nv = INIT; m_pend = 0;
      m_pf = 0; m_cnt = 0; m_rd = 0; m_sgq = 0;
    end else begin
      ok = supply_good && m_sgq;
      b = (m_cnt != 0);
      wacc = ok && req_valid && req_write && !b;
      ld = wacc && req_addr == 0 && !m_vol;
      nwr = m_wr; nvol = m_vol; nshdn = m_shdn; nnv = m_nv;
      npend = m_pend; npf = m_pf; ncnt = m_cnt; nrd = m_rd;
      if (ok && req_valid && !req_write) begin
        if (req_addr == 0) nrd = m_vol ? m_wr : m_nv;
        else if (req_addr == 2) nrd = m_vol * 128 + m_shdn * 64 + b * 32;
        else nrd = 0;
      end
      if (!supply_good) nwr = 64;
      else if (!m_sgq) nwr = m_nv;
      else if (wacc && req_addr == 0) nwr = req_wdata & 8'h7f;
      if (wacc && req_addr == 2) begin
        nvol = req_wdata[7]; nshdn = req_wdata[6];
      end
      if (ld) begin npend = req_wdata & 8'h7f; npf = 1; end
      if (b) begin
        if (m_cnt == 1) nnv = m_pend;
        ncnt = m_cnt - 1;
      end else if (frame_done && (m_pf || ld)) begin
        ncnt = N; npf = 0;
      end
      m_wr = nwr; m_vol = nvol; m_shdn = nshdn; m_nv = nnv; m_pend = npend;
      m_pf = npf; m_cnt = ncnt; m_rd = nrd; m_sgq = supply_good;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R5 model wiper", wiper_code, m_wr);
      check("R6 model busy", busy, m_cnt != 0);
      check("R8 model shutdown", shutdown, !run_pin || !m_shdn);
      check("R3 model rd_data", rd_data, m_rd);
    end
  end

  always @(negedge clk) if (busy) busy_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic req(input bit wr, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 midscale while supply low", wiper_code, 8'h40);
    check("R8 no shutdown at reset", shutdown, 0);
    req(1, 2'b10, 8'h80);                 // ignored: supply low
    supply_good = 1'b1;
    @(negedge clk);
    check("R2 recall of startup code", wiper_code, INIT);
    @(negedge clk);
    req(0, 2'b10, 0);
    check("R1 control reset value", rd_data, 8'h40);
    check("R10 write during supply low ignored", rd_data[7], 0);
    req(0, 2'b00, 0);
    check("R3 addr 00 with C=0 reads startup", rd_data, INIT);

    req(1, 2'b00, 8'hF7);
    check("R5 startup write moves wiper, bit 7 dropped", wiper_code, 8'h77);
    check("R6 no busy before frame end", busy, 0);
    busy_cnt = 0;
    frame();
    check("R6 busy after frame end", busy, 1);
    req(1, 2'b10, 8'h80);
    req(1, 2'b00, 8'h11);
    check("R7 wiper write locked during store", wiper_code, 8'h77);
    req(0, 2'b10, 0);
    check("R7 control write locked, R4 busy bit", rd_data, 8'h60);
    req(0, 2'b00, 0);
    check("R6 old startup value during store", rd_data, INIT);
    while (busy) @(negedge clk);
    check("R6 busy length", busy_cnt, N);
    req(0, 2'b00, 0);
    check("R6 new startup value after store", rd_data, 8'h77);
    frame();
    check("R6 frame end without write stays idle", busy, 0);

    req(1, 2'b10, 8'hFF);
    req(0, 2'b10, 0);
    check("R4 control write keeps only bits 7:6", rd_data, 8'hC0);
    req(1, 2'b00, 8'h2A);
    check("R3 addr 00 with C=1 writes wiper", wiper_code, 8'h2A);
    req(0, 2'b00, 0);
    check("R3 addr 00 with C=1 reads wiper", rd_data, 8'h2A);
    frame();
    check("R6 wiper write starts no store", busy, 0);
    req(1, 2'b10, 8'h40);
    req(0, 2'b00, 0);
    check("R5 startup read value", rd_data, 8'h77);
    check("R5 startup read leaves wiper", wiper_code, 8'h2A);
    req(1, 2'b01, 8'h55);
    req(1, 2'b11, 8'h55);
    req(0, 2'b01, 0);
    check("R3 reserved reads zero", rd_data, 0);
    check("R3 reserved write no effect", wiper_code, 8'h2A);

    run_pin = 1'b0;
    @(negedge clk);
    check("R8 pin shutdown", shutdown, 1);
    check("R9 wiper held in shutdown", wiper_code, 8'h2A);
    req(1, 2'b10, 8'h80);
    run_pin = 1'b1;
    @(negedge clk);
    check("R8 control bit shutdown", shutdown, 1);
    req(1, 2'b00, 8'h33);
    check("R9 wiper writable in shutdown", wiper_code, 8'h33);
    req(1, 2'b10, 8'hC0);
    check("R8 both high leaves shutdown", shutdown, 0);
    check("R9 wiper after shutdown", wiper_code, 8'h33);

    @(negedge clk); supply_good = 1'b0;
    @(negedge clk);
    check("R1 midscale on supply drop", wiper_code, 8'h40);
    req(1, 2'b00, 8'h05);
    check("R10 write ignored while supply low", wiper_code, 8'h40);
    @(negedge clk);
    supply_good = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'b10; req_wdata = 8'h00;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R2 recall after supply drop", wiper_code, 8'h77);
    req(0, 2'b10, 0);
    check("R10 recall-edge write ignored", rd_data, 8'hC0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule